// File: doc/BRIEF.md
# Pair-Scaled Block Quantizer

This block turns a group of sixteen signed values, each given as a sign, an unsigned 8-bit mantissa and an 8-bit exponent, into a compact block format. The format carries two levels of scale. One 8-bit exponent is shared by the whole group. Each pair of neighbouring elements then adds a 1-bit extra scale on top of it. Each element keeps a sign and a 7-bit magnitude. A finished block is 144 bits wide, which is 9 bits per element on average.

An element with a mantissa of zero is a zero element, whatever its exponent field holds. The shared exponent is the largest exponent among the non-zero elements. A pair whose members are both at least one binade below that maximum sets its extra-scale bit, and both members gain one bit of precision. Each mantissa is shifted right by the distance to its scale, rounded to nearest with ties to even, and saturated to 7 bits.

Blocks enter as one parallel vector on a valid/ready handshake. They pass through three registered stages: exponent search, then shift and round, then pack. They leave on the same kind of handshake. Back-pressure from the output freezes every stage at once.

Top module: `psq_quantizer`

## Requirements
- R1: `out_block[7:0]` holds the largest `in_exp` among elements whose mantissa is non-zero. The exponent field of an element with a zero mantissa takes no part in the search. When every mantissa is zero, this field is 0.
- R2: Bit 8+p of `out_block` is the extra-scale bit of pair p, which holds elements 2p and 2p+1. It is 1 exactly when the shared exponent is non-zero and each element of the pair either has a zero mantissa or has an exponent strictly below the shared exponent.
- R3: For element i, the magnitude field `out_block[16+8i+6 : 16+8i]` is the mantissa divided by 2^(shared − bit − exponent), rounded to nearest with ties to even. Here "bit" is the extra-scale bit of the element's pair.
- R4: A rounded magnitude above 127 is replaced by 127. This includes the case where rounding itself carries past 7 bits.
- R5: The sign bit `out_block[16+8i+7]` equals `in_sign[i]`, except that it is 0 whenever that element's magnitude field is 0.
- R6: A block whose sixteen mantissas are all zero produces an all-zero 144-bit output, whatever its sign and exponent inputs hold.
- R7: Field layout, from bit 0 upward: the shared exponent in bits [7:0], the eight pair bits in bits [15:8] with pair 0 lowest, then element 0 through element 15 at 8 bits each. Each element byte has its sign in the top bit.
- R8: `out_valid` is 0 during and after reset until a block arrives. A block accepted at a rising edge appears on the outputs right after the third rising edge, counting the accepting edge as the first, provided `out_ready` was high at all three edges.
- R9: `in_ready` equals `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_block` stay unchanged. No accepted block is lost or reordered.
- R10: With `out_ready` held high, one block is accepted and one block is delivered on every cycle. A back-to-back stream of N blocks has fully drained three cycles after the last one is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block can be taken this cycle |
| in_sign | input | 16 | Sign of each element, element i at bit i |
| in_exp | input | 128 | Element exponents, element i at bits [8i+7:8i] |
| in_mant | input | 128 | Unsigned element mantissas, element i at bits [8i+7:8i] |
| out_valid | output | 1 | Packed block present |
| out_ready | input | 1 | Consumer takes the packed block |
| out_block | output | 144 | Packed block in the layout of R7 |

## Verification
A block handed over at a falling edge is accepted at the next rising edge. When the output side stays ready, its packed result is due exactly three falling edges later. The bench logs the falling-edge count at each acceptance and compares each delivered block against the oldest entry still owed, at the falling edge where `out_valid` and `out_ready` are both high. In ready-only stretches it also checks that the distance between acceptance and delivery is exactly three. After a stalled falling edge, the bench requires the next falling edge to show the same block unchanged. At the end of each stream, the owed list must be empty within the predicted number of idle cycles.

// File: rtl/psq_pkg.sv
package psq_pkg;

    localparam int unsigned PSQ_ELEMS  = 16;
    localparam int unsigned PSQ_GROUP  = 2;
    localparam int unsigned PSQ_EXP_W  = 8;
    localparam int unsigned PSQ_MANT_W = 8;
    localparam int unsigned PSQ_MAG_W  = 7;

    // Width of one packed block: shared exponent, one bit per group, one code per element.
    function automatic int unsigned psq_block_bits(
        input int unsigned elems,
        input int unsigned group,
        input int unsigned exp_w,
        input int unsigned mag_w
    );
        return exp_w + elems / group + elems * (mag_w + 1);
    endfunction

endpackage

// File: rtl/psq_expsearch.sv
module psq_expsearch #(
    parameter int unsigned ELEMS  = 16,
    parameter int unsigned GROUP  = 2,
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned MANT_W = 8
) (
    input  logic [ELEMS*EXP_W-1:0]  exp_flat,
    input  logic [ELEMS*MANT_W-1:0] mant_flat,
    output logic [EXP_W-1:0]        shared_exp,
    output logic [ELEMS/GROUP-1:0]  micro
);
    localparam int unsigned SUBS = ELEMS / GROUP;

    logic [ELEMS-1:0] elem_nz;
    logic [ELEMS-1:0] elem_below;

    // Largest exponent over the non-zero elements.
    always_comb begin
        shared_exp = '0;
        for (int i = 0; i < ELEMS; i++) begin
            elem_nz[i] = |mant_flat[i*MANT_W +: MANT_W];
            if (elem_nz[i] && (exp_flat[i*EXP_W +: EXP_W] > shared_exp)) begin
                shared_exp = exp_flat[i*EXP_W +: EXP_W];
            end
        end
    end

    // An element qualifies for the extra scale when it is zero or below the maximum.
    always_comb begin
        for (int i = 0; i < ELEMS; i++) begin
            elem_below[i] = !elem_nz[i] || (exp_flat[i*EXP_W +: EXP_W] < shared_exp);
        end
    end

    genvar p;
    generate
        for (p = 0; p < SUBS; p++) begin : g_grp
            assign micro[p] = (shared_exp != '0) && (&elem_below[p*GROUP +: GROUP]);
        end
    endgenerate

endmodule

// File: rtl/psq_round.sv
module psq_round #(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned MANT_W = 8,
    parameter int unsigned MAG_W  = 7
) (
    input  logic [EXP_W-1:0]  shared_exp,
    input  logic              micro,
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp,
    input  logic [MANT_W-1:0] mant,
    output logic [MAG_W:0]    code
);
    localparam int unsigned SH_W = EXP_W + 1;
    localparam logic [MANT_W:0] MAG_MAX = (MANT_W + 1)'((1 << MAG_W) - 1);

    logic [SH_W-1:0]       shift;
    logic [2*MANT_W-1:0]   ext;
    logic [MANT_W-1:0]     trunc;
    logic [MANT_W-1:0]     rem;
    logic                  rnd_up;
    logic [MANT_W:0]       sum;
    logic [MAG_W-1:0]      mag;

    // Distance from the element's own scale to the pair scale.
    assign shift = {1'b0, shared_exp} - {{EXP_W{1'b0}}, micro} - {1'b0, exp};

    // Shift with a guard field below the binary point so the dropped bits stay visible.
    assign ext   = {mant, {MANT_W{1'b0}}} >> shift;
    assign trunc = ext[2*MANT_W-1:MANT_W];
    assign rem   = ext[MANT_W-1:0];

    // Nearest, ties go to the even neighbour.
    assign rnd_up = rem[MANT_W-1] & ((|rem[MANT_W-2:0]) | trunc[0]);
    assign sum    = {1'b0, trunc} + {{MANT_W{1'b0}}, rnd_up};

    assign mag  = (sum > MAG_MAX) ? MAG_MAX[MAG_W-1:0] : sum[MAG_W-1:0];
    assign code = {sign & (|mag), mag};

endmodule

// File: rtl/psq_pack.sv
module psq_pack #(
    parameter int unsigned ELEMS = 16,
    parameter int unsigned GROUP = 2,
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAG_W = 7
) (
    input  logic [EXP_W-1:0]               shared_exp,
    input  logic [ELEMS/GROUP-1:0]         micro,
    input  logic [ELEMS*(MAG_W+1)-1:0]     codes,
    output logic [EXP_W+ELEMS/GROUP+ELEMS*(MAG_W+1)-1:0] block
);
    localparam int unsigned SUBS   = ELEMS / GROUP;
    localparam int unsigned CODE_W = MAG_W + 1;
    localparam int unsigned BASE   = EXP_W + SUBS;

    assign block[EXP_W-1:0]    = shared_exp;
    assign block[BASE-1:EXP_W] = micro;

    genvar i;
    generate
        for (i = 0; i < ELEMS; i++) begin : g_elem
            assign block[BASE + i*CODE_W +: CODE_W] = codes[i*CODE_W +: CODE_W];
        end
    endgenerate

endmodule

// File: rtl/psq_quantizer.sv
module psq_quantizer
    import psq_pkg::*;
#(
    parameter int unsigned ELEMS  = PSQ_ELEMS,
    parameter int unsigned GROUP  = PSQ_GROUP,
    parameter int unsigned EXP_W  = PSQ_EXP_W,
    parameter int unsigned MANT_W = PSQ_MANT_W,
    parameter int unsigned MAG_W  = PSQ_MAG_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [ELEMS-1:0]           in_sign,
    input  logic [ELEMS*EXP_W-1:0]     in_exp,
    input  logic [ELEMS*MANT_W-1:0]    in_mant,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [psq_block_bits(ELEMS, GROUP, EXP_W, MAG_W)-1:0] out_block
);
    localparam int unsigned SUBS   = ELEMS / GROUP;
    localparam int unsigned CODE_W = MAG_W + 1;
    localparam int unsigned BLK_W  = psq_block_bits(ELEMS, GROUP, EXP_W, MAG_W);
    localparam int unsigned BASE   = EXP_W + SUBS;

    logic adv;
    assign adv      = out_ready;
    assign in_ready = out_ready;

    // ---------------- stage 1: exponent search ----------------
    logic [EXP_W-1:0]        srch_shared;
    logic [SUBS-1:0]         srch_micro;

    psq_expsearch #(
        .ELEMS (ELEMS),
        .GROUP (GROUP),
        .EXP_W (EXP_W),
        .MANT_W(MANT_W)
    ) u_search (
        .exp_flat  (in_exp),
        .mant_flat (in_mant),
        .shared_exp(srch_shared),
        .micro     (srch_micro)
    );

    logic                    s1_v;
    logic [ELEMS-1:0]        s1_sign;
    logic [ELEMS*EXP_W-1:0]  s1_exp;
    logic [ELEMS*MANT_W-1:0] s1_mant;
    logic [EXP_W-1:0]        s1_shared;
    logic [SUBS-1:0]         s1_micro;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
        end else if (adv) begin
            s1_v <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            s1_sign   <= in_sign;
            s1_exp    <= in_exp;
            s1_mant   <= in_mant;
            s1_shared <= srch_shared;
            s1_micro  <= srch_micro;
        end
    end

    // ---------------- stage 2: shift and round ----------------
    logic [ELEMS*CODE_W-1:0] rnd_codes;

    genvar i;
    generate
        for (i = 0; i < ELEMS; i++) begin : g_rnd
            psq_round #(
                .EXP_W (EXP_W),
                .MANT_W(MANT_W),
                .MAG_W (MAG_W)
            ) u_round (
                .shared_exp(s1_shared),
                .micro     (s1_micro[i/GROUP]),
                .sign      (s1_sign[i]),
                .exp       (s1_exp[i*EXP_W +: EXP_W]),
                .mant      (s1_mant[i*MANT_W +: MANT_W]),
                .code      (rnd_codes[i*CODE_W +: CODE_W])
            );
        end
    endgenerate

    logic                    s2_v;
    logic [ELEMS*CODE_W-1:0] s2_codes;
    logic [EXP_W-1:0]        s2_shared;
    logic [SUBS-1:0]         s2_micro;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v <= 1'b0;
        end else if (adv) begin
            s2_v <= s1_v;
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            s2_codes  <= rnd_codes;
            s2_shared <= s1_shared;
            s2_micro  <= s1_micro;
        end
    end

    // ---------------- stage 3: pack ----------------
    logic [BLK_W-1:0] pk_block;

    psq_pack #(
        .ELEMS(ELEMS),
        .GROUP(GROUP),
        .EXP_W(EXP_W),
        .MAG_W(MAG_W)
    ) u_pack (
        .shared_exp(s2_shared),
        .micro     (s2_micro),
        .codes     (s2_codes),
        .block     (pk_block)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (adv) begin
            out_valid <= s2_v;
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            out_block <= pk_block;
        end
    end

    // ---------------- checks ----------------
    logic chk_search_ok;
    logic chk_micro_ok;
    logic chk_sign_ok;

    // Stage-1 registers against the element data they were derived from.
    always_comb begin
        logic any_nz;
        logic hit;
        chk_search_ok = 1'b1;
        any_nz        = 1'b0;
        hit           = 1'b0;
        for (int k = 0; k < ELEMS; k++) begin
            if (|s1_mant[k*MANT_W +: MANT_W]) begin
                any_nz = 1'b1;
                if (s1_exp[k*EXP_W +: EXP_W] > s1_shared) chk_search_ok = 1'b0;
                if (s1_exp[k*EXP_W +: EXP_W] == s1_shared) hit = 1'b1;
            end
        end
        if (any_nz && !hit) chk_search_ok = 1'b0;
        if (!any_nz && (s1_shared != '0)) chk_search_ok = 1'b0;
    end

    always_comb begin
        chk_micro_ok = 1'b1;
        for (int p = 0; p < SUBS; p++) begin
            logic room;
            room = (s1_shared != '0);
            for (int q = 0; q < GROUP; q++) begin
                if ((|s1_mant[(p*GROUP+q)*MANT_W +: MANT_W]) &&
                    !(s1_exp[(p*GROUP+q)*EXP_W +: EXP_W] < s1_shared)) begin
                    room = 1'b0;
                end
            end
            if (s1_micro[p] != room) chk_micro_ok = 1'b0;
        end
    end

    always_comb begin
        chk_sign_ok = 1'b1;
        for (int k = 0; k < ELEMS; k++) begin
            if ((out_block[BASE + k*CODE_W +: MAG_W] == '0) && out_block[BASE + k*CODE_W + MAG_W]) begin
                chk_sign_ok = 1'b0;
            end
        end
    end

    assert_search_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s1_v |-> chk_search_ok);

    assert_micro_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_v |-> chk_micro_ok);

    assert_zero_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> chk_sign_ok);

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 out_ready ##1 out_ready |=> out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_block)));

endmodule

// File: tb/psq_quantizer_tb_top.sv
`timescale 1ns/1ps
module psq_quantizer_tb_top;

    localparam int N     = 16;
    localparam int BLK_W = 144;
    localparam int QDEP  = 4096;

    logic             clk;
    logic             rst_n;
    logic             in_valid;
    logic             in_ready;
    logic [N-1:0]     in_sign;
    logic [N*8-1:0]   in_exp;
    logic [N*8-1:0]   in_mant;
    logic             out_valid;
    logic             out_ready;
    logic [BLK_W-1:0] out_block;

    psq_quantizer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_sign  (in_sign),
        .in_exp   (in_exp),
        .in_mant  (in_mant),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_block(out_block)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int nchecks = 0;
    int nfails  = 0;
    int cyc     = 0;
    bit done    = 0;

    int ve [N];
    int vm [N];
    int vs [N];

    logic [BLK_W-1:0] exp_q  [QDEP];
    int               cyc_q  [QDEP];
    bit               lit_q  [QDEP];
    int wr = 0;
    int rd = 0;

    bit               lat_en   = 0;
    bit               lit_next = 0;
    bit               hold_pend = 0;
    logic [BLK_W-1:0] hold_val;

    task automatic chk(input bit ok, input string tag, input logic [BLK_W-1:0] act, input logic [BLK_W-1:0] expv);
        nchecks++;
        if (!ok) begin
            nfails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Expected packed block computed from the arithmetic of R1..R7.
    function automatic logic [BLK_W-1:0] model();
        logic [BLK_W-1:0] b;
        int e_max;
        int u [N/2];
        e_max = 0;
        for (int i = 0; i < N; i++)
            if (vm[i] != 0 && ve[i] > e_max) e_max = ve[i];
        for (int p = 0; p < N/2; p++) begin
            u[p] = (e_max > 0) &&
                   (vm[2*p] == 0 || ve[2*p] < e_max) &&
                   (vm[2*p+1] == 0 || ve[2*p+1] < e_max);
        end
        b = '0;
        b[7:0] = 8'(e_max);
        for (int p = 0; p < N/2; p++) b[8+p] = u[p][0];
        for (int i = 0; i < N; i++) begin
            int sh, q, den, r, sg;
            q = 0;
            if (vm[i] != 0) begin
                sh = e_max - u[i/2] - ve[i];
                if (sh < 16) begin
                    den = 1 << sh;
                    q = vm[i] / den;
                    r = vm[i] % den;
                    if (sh > 0 && ((2*r > den) || (2*r == den && (q % 2) == 1))) q++;
                end
            end
            if (q > 127) q = 127;
            sg = (vs[i] != 0 && q != 0) ? 1 : 0;
            b[16+8*i +: 8] = {sg[0], 7'(q)};
        end
        return b;
    endfunction

    task automatic compare(input logic [BLK_W-1:0] act, input logic [BLK_W-1:0] expv, input bit lit);
        chk(act[7:0] == expv[7:0], "R1 shared exponent", act, expv);
        chk(act[15:8] == expv[15:8], "R2 pair bits", act, expv);
        for (int i = 0; i < N; i++) begin
            chk(act[16+8*i +: 7] == expv[16+8*i +: 7], "R3 R4 magnitude", act, expv);
            chk(act[16+8*i+7] == expv[16+8*i+7], "R5 sign", act, expv);
        end
        if (lit) begin
            chk(act[7:0] == 8'd7 && act[15:8] == 8'hFB && act[63:56] == 8'hE4 &&
                act[55:16] == '0 && act[143:64] == '0, "R7 layout", act, expv);
        end
    endtask

    task automatic step(input bit rdy, input bit vld);
        @(negedge clk);
        out_ready = rdy;
        in_valid  = vld;
        for (int i = 0; i < N; i++) begin
            in_exp[i*8 +: 8]  = 8'(ve[i]);
            in_mant[i*8 +: 8] = 8'(vm[i]);
            in_sign[i]        = vs[i][0];
        end
        #1;
        if (hold_pend) chk(out_valid === 1'b1 && out_block === hold_val, "R9 hold", out_block, hold_val);
        chk(in_ready === out_ready, "R9 ready", BLK_W'(in_ready), BLK_W'(out_ready));
        hold_pend = out_valid && !out_ready;
        hold_val  = out_block;
        if (out_valid && out_ready) begin
            if (rd == wr) begin
                chk(1'b0, "R8 unexpected block", out_block, '0);
            end else begin
                compare(out_block, exp_q[rd], lit_q[rd]);
                if (lat_en) chk(cyc - cyc_q[rd] == 3, "R8 latency", BLK_W'(cyc - cyc_q[rd]), BLK_W'(3));
                rd++;
            end
        end
        if (vld && rdy) begin
            exp_q[wr] = model();
            cyc_q[wr] = cyc;
            lit_q[wr] = lit_next;
            wr++;
        end
        lit_next = 0;
        cyc++;
    endtask

    task automatic set_pattern(input int k, input int base);
        for (int i = 0; i < N; i++) begin
            vm[i] = ((k*37 + i*11 + (k >> 3)) % 256);
            if ((k + i) % 9 == 0) vm[i] = 0;
            ve[i] = base - ((k*7 + i*3) % 12);
            vs[i] = ((k*3 + i) >> 1) & 1;
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        in_sign = '0; in_exp = '0; in_mant = '0;
        for (int i = 0; i < N; i++) begin ve[i] = 0; vm[i] = 0; vs[i] = 0; end
        repeat (3) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R8 reset valid", BLK_W'(out_valid), '0);
        end
        rst_n = 1'b1;
        step(1, 0);
        chk(out_valid === 1'b0, "R8 idle after reset", BLK_W'(out_valid), '0);
        lat_en = 1;

        // R6: all mantissas zero, signs and exponents set.
        for (int i = 0; i < N; i++) begin vm[i] = 0; ve[i] = 200 + i; vs[i] = 1; end
        step(1, 1);
        // R7: one known element at a known place.
        for (int i = 0; i < N; i++) begin vm[i] = 0; ve[i] = 3; vs[i] = 0; end
        vm[5] = 100; ve[5] = 7; vs[5] = 1;
        lit_next = 1;
        step(1, 1);
        // top of exponent range
        set_pattern(5, 255);
        step(1, 1);
        // every exponent zero: no pair bits, saturation at shift 0
        set_pattern(11, 0);
        for (int i = 0; i < N; i++) ve[i] = 0;
        step(1, 1);
        // element 15 alone at the maximum, all others one binade lower
        for (int i = 0; i < N; i++) begin vm[i] = 255 - i; ve[i] = 40; vs[i] = i & 1; end
        ve[15] = 41;
        step(1, 1);
        repeat (4) step(1, 0);
        chk(rd == wr, "R6 R7 drained", BLK_W'(rd), BLK_W'(wr));

        // R3 R4 R10: sweep mantissa 0..255 over shifts 0..9, back to back.
        for (int k = 0; k < 2560; k++) begin
            set_pattern(k, 25);
            vm[0] = 200; ve[0] = 30; vs[0] = 0;
            vm[1] = k % 256; ve[1] = 30 - (k / 256); vs[1] = k & 1;
            step(1, 1);
        end
        repeat (3) step(1, 0);
        chk(rd == wr, "R10 stream drained", BLK_W'(rd), BLK_W'(wr));

        // R9: sparse input and stalling output.
        lat_en = 0;
        for (int k = 0; k < 400; k++) begin
            set_pattern(k + 77, 60 + (k % 7) * 25);
            step(((k*5) % 7) < 4, (k % 3) != 0);
        end
        repeat (6) step(1, 0);
        chk(rd == wr, "R9 no loss", BLK_W'(rd), BLK_W'(wr));

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchecks++;
            nfails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
            $finish;
        end
    end

endmodule